// File: doc/BRIEF.md
# Dual-Core Tick Timer

This block is a memory-mapped timer on a plain 32-bit register bus (address, write enable, write data, combinational read data). It gives each processor core its own 32-bit compare channel and its own interrupt line, and it holds one shared 64-bit free-running counter. Software arms a compare channel by writing a match value, zeroing the channel's count and enabling it. The channel then counts up at a prescaled rate. When the count reaches the match value, the channel's status bit is set and, if the channel's interrupt is enabled, that core's interrupt line rises.

The 64-bit counter is never read word by word while it runs. A command written to its control word copies the whole 64-bit value into a snapshot pair in one clock, so the high and low halves always belong together. A second command reloads the counter from a staged 64-bit value. Every counter has its own prescaler: a 16-bit divider N in the upper half of its control word makes it advance once every N+1 clocks.

The 64-bit command path is decoded in a small command selector with three named outcomes. CMD_IDLE covers any write that is not a command and every cycle without a write. CMD_LATCH is a write with bit0 = 1 and bit1 = 0. CMD_LOAD is a write with bit0 = 1 and bit1 = 1. Each outcome lasts a single cycle, and the selector always returns to CMD_IDLE on the next cycle.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero. Any address outside the map (for example 0x90) reads zero, and a write to such an address has no effect.
- R2: The compare channel i has a control word at 0x00+4i. Its bit0 enables counting. When bit0 is set, the count at 0x48+4i advances once every N+1 clocks, where N is control bits [31:16]. The first step comes N+1 clocks after the control write. When bit0 is clear, the count holds its value.
- R3: When a step brings channel i's count equal to its match value at 0x18+4i, bit i of the status word at 0x60 is set on that clock. core_irq[i] follows status bit i ANDed with control bit1 and is registered, so it rises one clock after the status bit and falls one clock after either input drops.
- R4: The status word is write-one-to-clear. Writing it clears exactly the bits set in the data. Writing 0xFFFF clears every bit.
- R5: A write to a channel's count register loads the written value and restarts that channel's prescaler phase. The next step comes N+1 clocks later.
- R6: The 64-bit counter runs freely after reset and advances once every N+1 clocks, where N is bits [31:16] of its control word at 0x68. Its live value reads at 0x6C (low word) and 0x70 (high word), and the carry from the low word into the high word is taken in one step.
- R7: Writing 0x68 with bit0 = 1 and bit1 = 0 copies the live 64-bit value, as it stood before that clock's step, into the snapshot words at 0x7C (low) and 0x80 (high). The snapshot then holds until the next such command.
- R8: Writing 0x68 with bit0 = 1 and bit1 = 1 loads the counter from the staged words at 0x74 (low) and 0x78 (high) and restarts its prescaler phase.
- R9: Bits [1:0] of 0x68 are command strobes. They always read zero, while the divider field keeps the value written with it. A write with bit0 = 0 issues no command.
- R10: The match words and the word at 0x64 store and read back the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_we | input | 1 | Write strobe for one clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_irq | output | NUM_CH (2) | Registered interrupt, one per compare channel |

## Verification
The assertions check, on every cycle, these properties:
- A stopped channel's count holds when nothing is written.
- A compare hit always leaves its status bit set.
- A clear write always clears its status bit unless a hit arrives in the same clock.
- An interrupt can only rise from an enabled pending status.
- The 64-bit counter moves by at most one per clock outside writes.
- The latch and load commands land the right 64-bit value.
- The strobe bits read zero.

The exact cycle positions can only be shown by the bench's scenarios: the first step N+1 clocks after enable, the hit clock, the one-clock interrupt lag, the phase restart after a count write, and the carry across the 32-bit boundary. The same holds for snapshot hold across later non-command writes and for the reset and unmapped read values.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int DATA_W  = 32;
    localparam int DIV_W   = 16;
    localparam int DIV_LSB = 16;
    localparam int WIDE_W  = 2 * DATA_W;

    // Offsets are fixed because software decodes them.
    localparam int OFS_CTRL_BASE  = 'h00;
    localparam int OFS_MATCH_BASE = 'h18;
    localparam int OFS_COUNT_BASE = 'h48;
    localparam int OFS_STATUS     = 'h60;
    localparam int OFS_WDOG       = 'h64;
    localparam int OFS_WCTRL      = 'h68;
    localparam int OFS_LIVE_LO    = 'h6C;
    localparam int OFS_LIVE_HI    = 'h70;
    localparam int OFS_LOAD_LO    = 'h74;
    localparam int OFS_LOAD_HI    = 'h78;
    localparam int OFS_SNAP_LO    = 'h7C;
    localparam int OFS_SNAP_HI    = 'h80;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_LATCH = 2'd1,
        CMD_LOAD  = 2'd2
    } wide_cmd_e;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase;

    // A phase above a newly lowered divider wraps at once.
    assign tick = run && !restart && (phase >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (restart || !run || tick)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

endmodule

// File: rtl/tick_match_chan.sv
module tick_match_chan
    import tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              match_we,
    input  logic              count_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] match_q,
    output logic [DATA_W-1:0] count_q,
    output logic              hit,
    output logic              cnt_en,
    output logic              irq_en
);

    localparam int PAD_W = DIV_LSB - 3;

    logic [DIV_W-1:0] div_q;
    logic [2:0]       en_q;
    logic             tick;
    logic [DATA_W-1:0] count_next;

    assign cnt_en     = en_q[0];
    assign irq_en     = en_q[1];
    assign ctrl_q     = {div_q, {PAD_W{1'b0}}, en_q};
    assign count_next = count_q + 1'b1;
    assign hit        = tick && (count_next == match_q);

    tick_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cnt_en),
        .restart (ctrl_we || count_we),
        .div     (div_q),
        .tick    (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            en_q    <= '0;
            match_q <= '0;
            count_q <= '0;
        end else begin
            if (ctrl_we) begin
                div_q <= wdata[DIV_LSB +: DIV_W];
                en_q  <= wdata[2:0];
            end
            if (match_we)
                match_q <= wdata;
            if (count_we)
                count_q <= wdata;
            else if (tick)
                count_q <= count_next;
        end
    end

endmodule

// File: rtl/tick_wide_ctr.sv
module tick_wide_ctr
    import tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              load_lo_we,
    input  logic              load_hi_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [WIDE_W-1:0] live_q,
    output logic [WIDE_W-1:0] snap_q,
    output logic [WIDE_W-1:0] load_q
);

    wide_cmd_e        cmd;
    logic [DIV_W-1:0] div_q;
    logic             tick;

    assign ctrl_q = {div_q, {DIV_LSB{1'b0}}};

    // Command selector: one cycle per command, otherwise CMD_IDLE.
    always_comb begin
        cmd = CMD_IDLE;
        if (ctrl_we) begin
            unique case (wdata[1:0])
                2'b01:   cmd = CMD_LATCH;
                2'b11:   cmd = CMD_LOAD;
                default: cmd = CMD_IDLE;
            endcase
        end
    end

    tick_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (1'b1),
        .restart (cmd == CMD_LOAD),
        .div     (div_q),
        .tick    (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            live_q <= '0;
            snap_q <= '0;
            load_q <= '0;
        end else begin
            if (ctrl_we)
                div_q <= wdata[DIV_LSB +: DIV_W];
            if (load_lo_we)
                load_q[DATA_W-1:0] <= wdata;
            if (load_hi_we)
                load_q[WIDE_W-1:DATA_W] <= wdata;
            unique case (cmd)
                CMD_LOAD: begin
                    live_q <= load_q;
                end
                CMD_LATCH: begin
                    snap_q <= live_q;
                    if (tick) live_q <= live_q + 1'b1;
                end
                default: begin
                    if (tick) live_q <= live_q + 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] core_irq
);

    logic [NUM_CH-1:0][DATA_W-1:0] ch_ctrl;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_match;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_count;
    logic [NUM_CH-1:0]             hit_vec;
    logic [NUM_CH-1:0]             cen_vec;
    logic [NUM_CH-1:0]             ien_vec;
    logic [NUM_CH-1:0]             status_q;
    logic [NUM_CH-1:0]             clr_mask;
    logic [DATA_W-1:0]             wdog_q;
    logic [DATA_W-1:0]             wctrl_q;
    logic [WIDE_W-1:0]             live_cnt;
    logic [WIDE_W-1:0]             snap_cnt;
    logic [WIDE_W-1:0]             load_val;

    function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tick_match_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (bus_we && hit_addr(bus_addr, OFS_CTRL_BASE  + 4*i)),
            .match_we (bus_we && hit_addr(bus_addr, OFS_MATCH_BASE + 4*i)),
            .count_we (bus_we && hit_addr(bus_addr, OFS_COUNT_BASE + 4*i)),
            .wdata    (bus_wdata),
            .ctrl_q   (ch_ctrl[i]),
            .match_q  (ch_match[i]),
            .count_q  (ch_count[i]),
            .hit      (hit_vec[i]),
            .cnt_en   (cen_vec[i]),
            .irq_en   (ien_vec[i])
        );
    end

    tick_wide_ctr u_wide (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (bus_we && hit_addr(bus_addr, OFS_WCTRL)),
        .load_lo_we (bus_we && hit_addr(bus_addr, OFS_LOAD_LO)),
        .load_hi_we (bus_we && hit_addr(bus_addr, OFS_LOAD_HI)),
        .wdata      (bus_wdata),
        .ctrl_q     (wctrl_q),
        .live_q     (live_cnt),
        .snap_q     (snap_cnt),
        .load_q     (load_val)
    );

    assign clr_mask = (bus_we && hit_addr(bus_addr, OFS_STATUS)) ?
                      bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            core_irq <= '0;
            wdog_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | hit_vec;
            core_irq <= status_q & ien_vec;
            if (bus_we && hit_addr(bus_addr, OFS_WDOG))
                wdog_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_addr(bus_addr, OFS_CTRL_BASE  + 4*i)) bus_rdata = ch_ctrl[i];
            if (hit_addr(bus_addr, OFS_MATCH_BASE + 4*i)) bus_rdata = ch_match[i];
            if (hit_addr(bus_addr, OFS_COUNT_BASE + 4*i)) bus_rdata = ch_count[i];
        end
        if (hit_addr(bus_addr, OFS_STATUS))  bus_rdata = DATA_W'(status_q);
        if (hit_addr(bus_addr, OFS_WDOG))    bus_rdata = wdog_q;
        if (hit_addr(bus_addr, OFS_WCTRL))   bus_rdata = wctrl_q;
        if (hit_addr(bus_addr, OFS_LIVE_LO)) bus_rdata = live_cnt[DATA_W-1:0];
        if (hit_addr(bus_addr, OFS_LIVE_HI)) bus_rdata = live_cnt[WIDE_W-1:DATA_W];
        if (hit_addr(bus_addr, OFS_LOAD_LO)) bus_rdata = load_val[DATA_W-1:0];
        if (hit_addr(bus_addr, OFS_LOAD_HI)) bus_rdata = load_val[WIDE_W-1:DATA_W];
        if (hit_addr(bus_addr, OFS_SNAP_LO)) bus_rdata = snap_cnt[DATA_W-1:0];
        if (hit_addr(bus_addr, OFS_SNAP_HI)) bus_rdata = snap_cnt[WIDE_W-1:DATA_W];
    end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          bus_we,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic [NUM_CH-1:0]             core_irq,
    input logic [NUM_CH-1:0]             status_q,
    input logic [NUM_CH-1:0]             hit_vec,
    input logic [NUM_CH-1:0]             cen_vec,
    input logic [NUM_CH-1:0]             ien_vec,
    input logic [NUM_CH-1:0][DATA_W-1:0] ch_count,
    input logic [WIDE_W-1:0]             live_cnt,
    input logic [WIDE_W-1:0]             snap_cnt,
    input logic [WIDE_W-1:0]             load_val
);

    logic wctrl_wr;
    logic stat_wr;
    assign wctrl_wr = bus_we && (bus_addr == ADDR_W'(OFS_WCTRL));
    assign stat_wr  = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(!cen_vec[i]) && $past(!bus_we)) |-> (ch_count[i] == $past(ch_count[i])));

        assert_hit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(hit_vec[i]) |-> status_q[i]);

        assert_irq_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_irq[i]) |-> $past(status_q[i] && ien_vec[i]));

        assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(stat_wr && bus_wdata[i]) && !$past(hit_vec[i])) |-> !status_q[i]);
    end

    assert_wide_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> ((live_cnt == $past(live_cnt)) || (live_cnt == $past(live_cnt) + 64'd1)));

    assert_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wctrl_wr && bus_wdata[1:0] == 2'b01) |-> (snap_cnt == $past(live_cnt)));

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wctrl_wr && bus_wdata[1:0] == 2'b11) |-> (live_cnt == $past(load_val)));

    assert_strobe_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_WCTRL)) |-> (bus_rdata[1:0] == 2'b00));

endmodule

bind tick_timer tick_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  core_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    tick_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .core_irq  (core_irq)
    );

    // Monitor: pops expected items and compares with captured results.
    always @(posedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            logic [31:0] e, a;
            string t;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    task automatic push(input logic [31:0] act, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        act_q.push_back(act);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        push(bus_rdata, exp, tag);
    endtask

    task automatic chk_irq(input logic [1:0] exp, input string tag);
        #1;
        push({30'b0, core_irq}, {30'b0, exp}, tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state and unmapped reads
        rd(8'h00, 32'h0, "R1 ctrl0 reset");
        rd(8'h18, 32'h0, "R1 match0 reset");
        rd(8'h48, 32'h0, "R1 count0 reset");
        rd(8'h60, 32'h0, "R1 status reset");
        rd(8'h68, 32'h0, "R1 wide ctrl reset");
        rd(8'h7C, 32'h0, "R1 snap lo reset");
        rd(8'h74, 32'h0, "R1 load lo reset");
        chk_irq(2'b00, "R1 irq reset");
        wr(8'h90, 32'hDEAD_BEEF);
        rd(8'h90, 32'h0, "R1 unmapped read");

        // R10 storage registers
        wr(8'h18, 32'd5);
        rd(8'h18, 32'd5, "R10 match0 readback");
        wr(8'h64, 32'h0000_1234);
        rd(8'h64, 32'h0000_1234, "R10 word 0x64 readback");

        // R2 R3 channel 0, divider 0, match 5
        wr(8'h48, 32'd0);
        wr(8'h00, 32'h0000_0007);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k == 2) rd(8'h48, 32'd2, "R2 count0 after two clocks");
            if (k == 4) rd(8'h60, 32'h0, "R3 status before hit");
            if (k == 5) begin
                rd(8'h60, 32'h1, "R3 status on hit clock");
                chk_irq(2'b00, "R3 irq not yet high");
            end
            if (k == 6) chk_irq(2'b01, "R3 irq one clock after hit");
        end

        // R2 R3 disable channel 0: count stops, irq masked, status kept
        wr(8'h00, 32'h0);
        rd(8'h48, 32'd6, "R2 count0 at disable");
        chk_irq(2'b01, "R3 irq lag on disable");
        @(negedge clk);
        chk_irq(2'b00, "R3 irq masked");
        rd(8'h60, 32'h1, "R3 status kept when masked");
        idle(2);
        rd(8'h48, 32'd6, "R2 count0 holds while stopped");

        // R2 R3 channel 1, divider 2, match 3
        wr(8'h1C, 32'd3);
        wr(8'h4C, 32'd0);
        wr(8'h04, 32'h0002_0007);
        rd(8'h04, 32'h0002_0007, "R2 ctrl1 readback");
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k == 4) rd(8'h4C, 32'd1, "R2 count1 with divider 2");
            if (k == 8) rd(8'h60, 32'h1, "R3 ch1 not hit yet");
            if (k == 9) begin
                rd(8'h60, 32'h3, "R3 ch1 hit");
                chk_irq(2'b00, "R3 ch1 irq lag");
            end
            if (k == 10) chk_irq(2'b10, "R3 ch1 irq high");
        end

        // R4 write-one-to-clear
        wr(8'h60, 32'h1);
        rd(8'h60, 32'h2, "R4 clear bit0 only");
        wr(8'h60, 32'h0000_FFFF);
        rd(8'h60, 32'h0, "R4 clear all");
        chk_irq(2'b10, "R4 irq lag on clear");
        @(negedge clk);
        chk_irq(2'b00, "R4 irq low after clear");

        // R5 count write restarts phase
        wr(8'h4C, 32'd10);
        rd(8'h4C, 32'd10, "R5 count1 written");
        idle(2);
        rd(8'h4C, 32'd10, "R5 no step before N+1 clocks");
        @(negedge clk);
        rd(8'h4C, 32'd11, "R5 step after N+1 clocks");

        // R8 load, R6 carry
        wr(8'h74, 32'hFFFF_FFFE);
        wr(8'h78, 32'h0000_0001);
        rd(8'h78, 32'h1, "R8 staged high word");
        wr(8'h68, 32'h0000_0003);
        rd(8'h6C, 32'hFFFF_FFFE, "R8 loaded low");
        rd(8'h70, 32'h1, "R8 loaded high");
        idle(2);
        rd(8'h6C, 32'h0, "R6 low wrapped");
        rd(8'h70, 32'h2, "R6 carry into high");

        // R7 latch
        wr(8'h68, 32'h0000_0001);
        rd(8'h7C, 32'h0, "R7 snap low");
        rd(8'h80, 32'h2, "R7 snap high");
        rd(8'h6C, 32'h1, "R7 live kept running");

        // R9 bit1 alone is no command; strobes read zero
        wr(8'h68, 32'h0000_0002);
        idle(3);
        rd(8'h7C, 32'h0, "R9 snap low unchanged");
        rd(8'h80, 32'h2, "R9 snap high unchanged");
        rd(8'h68, 32'h0, "R9 strobes read zero");

        // R6 divider on wide counter, R8 reload
        wr(8'h68, 32'h0003_0003);
        rd(8'h68, 32'h0003_0000, "R9 divider kept, strobes zero");
        rd(8'h6C, 32'hFFFF_FFFE, "R8 reload low");
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 3) rd(8'h6C, 32'hFFFF_FFFE, "R6 no step before N+1");
            if (k == 4) rd(8'h6C, 32'hFFFF_FFFF, "R6 step after N+1");
        end

        idle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule